// File: doc/BRIEF.md
# Byte-Wide Non-Volatile Memory Controller

This block sits on a microcontroller data bus as four byte registers and controls a 1 KiB byte-wide non-volatile store, which is modelled inside it as a register array. Software selects a cell through two address bytes and uses the data byte for both directions. A read copies the addressed cell into the data byte. Programming changes a cell in one of three modes: erase, bit-clearing write, or erase followed by write.

Programming is protected by a timed unlock. A control write with the master-enable bit set opens a short window. Only a later control write that sets the program bit inside that window starts an operation. The operation keeps the block busy for a duration set by the phases it performs. During every accepted access the block requests a CPU stall for a fixed number of cycles. When programming finishes, it can raise a single-cycle ready interrupt request.

Top module: `nvm_ctrl`

## Requirements
- R1: After reset all four registers read 0x00, `cpu_stall` and `ready_irq` are low, and every cell reads 0xFF.
- R2: A control write (register at 0x3F) with bit 0 set loads the data register (0x40) from the cell at address {high byte 0x42, low byte 0x41}, and it raises `cpu_stall` for exactly RD_STALL cycles (4).
- R3: A control write with bit 2 (master enable) set makes bit 2 read back as 1 during the 4 cycles that follow that write. After that, hardware clears it.
- R4: A control write with bit 1 (program) set starts programming only when it lands in one of the 4 cycles after a master-enable write. A later arrival does nothing: the cell is unchanged, bit 1 reads 0 and no stall occurs.
- R5: The mode bits in the program write are bit 4 (M0) and bit 5 (M1). With M1=0 the cell is first erased to 0xFF. With M0=0 the data register is ANDed into the cell. So 00 stores the data byte, M0=1 only erases, and M1=1 only clears bits.
- R6: Bit 1 of the control register reads 1 while programming is busy. The busy time is ERASE_CYC + WRITE_CYC for mode 00, ERASE_CYC for erase only, and WRITE_CYC for write only.
- R7: An accepted program request raises `cpu_stall` for exactly PG_STALL cycles (2).
- R8: A program request made while an earlier operation is busy is ignored. Its cell keeps its value, and the running operation keeps its length.
- R9: In the cycle after bit 1 clears, `ready_irq` pulses high for one cycle, but only if control bit 3 was set and `int_en_global` is high. In all other cases it stays low.
- R10: Address high-byte bits above the 10-bit array address are ignored when a cell is selected.
- R11: A control write that sets both bit 0 and bit 1 performs only the read and starts no programming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Data-bus address used for register writes and readback |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Readback of the register addressed by `bus_addr` |
| int_en_global | input | 1 | Global interrupt enable from the CPU |
| cpu_stall | output | 1 | Stall request to the CPU |
| ready_irq | output | 1 | One-cycle ready interrupt request |

## Verification
The bench builds the block with ERASE_CYC=40 and WRITE_CYC=24, leaving the address width, window and stall lengths at their defaults. Because the two phases differ, a bench that measures the busy time can tell all three mode sums apart. Shortening them also puts full program cycles, the busy-reject case and the completion interrupt within a few hundred clocks. The unlock window is kept at 4 so that the bench can test the edges of the window cycle by cycle: the last accepting cycle and the first rejecting cycle.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  // Control register layout; the bit order is decoded by software.
  typedef struct packed {
    logic m1;    // bit 5: skip erase phase
    logic m0;    // bit 4: skip write phase
    logic rie;   // bit 3: ready interrupt enable
    logic mpe;   // bit 2: master (unlock) enable
    logic pe;    // bit 1: program start / busy flag
    logic rde;   // bit 0: read strobe
  } ctl_bits_t;
endpackage

// File: rtl/nvm_window.sv
module nvm_window #(
  parameter int WINDOW = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  output logic open
);
  localparam int WW = $clog2(WINDOW + 1);
  logic [WW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (arm)             cnt_d = WW'(WINDOW);
    else if (cnt_q != 0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;

  assign open = (cnt_q != 0);

  AST_WINDOW_STAYS_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
    (!open && !arm) |=> !open); // R3
endmodule

// File: rtl/nvm_busy.sv
module nvm_busy #(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)            cnt_d = load_val;
    else if (cnt_q != 0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;

  assign busy = (cnt_q != 0);
  assign last = (cnt_q == CNT_W'(1));

  AST_BUSY_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (cnt_q == $past(cnt_q) - 1'b1)); // R8
endmodule

// File: rtl/nvm_stall.sv
module nvm_stall #(
  parameter int RD_STALL = 4,
  parameter int PG_STALL = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_start,
  input  logic pg_start,
  output logic stall
);
  localparam int MAXS = (RD_STALL > PG_STALL) ? RD_STALL : PG_STALL;
  localparam int SW   = $clog2(MAXS + 1);
  logic [SW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (rd_start)        cnt_d = SW'(RD_STALL);
    else if (pg_start)   cnt_d = SW'(PG_STALL);
    else if (cnt_q != 0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;

  assign stall = (cnt_q != 0);

  AST_STALL_ONLY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !rd_start && !pg_start) |=> !stall); // R7
endmodule

// File: rtl/nvm_ctrl.sv
module nvm_ctrl #(
  parameter int         ADDR_W    = 10,
  parameter int         ERASE_CYC = 28800,
  parameter int         WRITE_CYC = 28800,
  parameter int         CNT_W     = 17,
  parameter int         WINDOW    = 4,
  parameter int         RD_STALL  = 4,
  parameter int         PG_STALL  = 2,
  parameter logic [7:0] REG_BASE  = 8'h3F
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] bus_addr,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       int_en_global,
  output logic       cpu_stall,
  output logic       ready_irq
);
  import nvm_pkg::*;

  localparam int         DEPTH   = 1 << ADDR_W;
  localparam int         HI_BITS = ADDR_W - 8;
  localparam logic [7:0] A_CTL   = REG_BASE;
  localparam logic [7:0] A_DAT   = REG_BASE + 8'd1;
  localparam logic [7:0] A_ALO   = REG_BASE + 8'd2;
  localparam logic [7:0] A_AHI   = REG_BASE + 8'd3;

  logic [7:0] mem_q [DEPTH];
  logic [7:0] dat_q, dat_d, alo_q, alo_d, ahi_q, ahi_d;
  logic       rie_q, rie_d, m0_q, m0_d, m1_q, m1_d, irq_q, irq_d;

  ctl_bits_t        wctl;
  logic             ctl_wr, rd_go, pg_go, win_open, busy, busy_last;
  logic             do_erase, do_write;
  logic [CNT_W-1:0] run_len;
  logic [ADDR_W-1:0] cell_addr;
  logic [7:0]       cell_old, cell_new;

  assign wctl      = ctl_bits_t'(bus_wdata[5:0]);
  assign ctl_wr    = bus_wr && (bus_addr == A_CTL);
  assign rd_go     = ctl_wr && wctl.rde;
  assign pg_go     = ctl_wr && !wctl.rde && wctl.pe && win_open && !busy;
  assign cell_addr = {ahi_q[HI_BITS-1:0], alo_q};
  assign cell_old  = mem_q[cell_addr];
  assign do_erase  = !wctl.m1;
  assign do_write  = !wctl.m0;

  always_comb begin
    run_len = '0;
    if (do_erase) run_len = run_len + CNT_W'(ERASE_CYC);
    if (do_write) run_len = run_len + CNT_W'(WRITE_CYC);
    if (run_len == '0) run_len = CNT_W'(1);
    cell_new = do_erase ? 8'hFF : cell_old;
    if (do_write) cell_new = cell_new & dat_q;
  end

  nvm_window #(.WINDOW(WINDOW)) u_window (
    .clk(clk), .rst_n(rst_n), .arm(ctl_wr && wctl.mpe), .open(win_open));

  nvm_busy #(.CNT_W(CNT_W)) u_busy (
    .clk(clk), .rst_n(rst_n), .load(pg_go), .load_val(run_len),
    .busy(busy), .last(busy_last));

  nvm_stall #(.RD_STALL(RD_STALL), .PG_STALL(PG_STALL)) u_stall (
    .clk(clk), .rst_n(rst_n), .rd_start(rd_go), .pg_start(pg_go),
    .stall(cpu_stall));

  // register next state
  always_comb begin
    dat_d = dat_q;
    alo_d = alo_q;
    ahi_d = ahi_q;
    rie_d = rie_q;
    m0_d  = m0_q;
    m1_d  = m1_q;
    if (bus_wr && bus_addr == A_DAT) dat_d = bus_wdata;
    if (bus_wr && bus_addr == A_ALO) alo_d = bus_wdata;
    if (bus_wr && bus_addr == A_AHI) ahi_d = bus_wdata;
    if (rd_go) dat_d = cell_old;
    if (ctl_wr) begin
      rie_d = wctl.rie;
      m0_d  = wctl.m0;
      m1_d  = wctl.m1;
    end
    irq_d = busy_last && rie_q && int_en_global;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dat_q <= '0;
      alo_q <= '0;
      ahi_q <= '0;
      rie_q <= 1'b0;
      m0_q  <= 1'b0;
      m1_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      dat_q <= dat_d;
      alo_q <= alo_d;
      ahi_q <= ahi_d;
      rie_q <= rie_d;
      m0_q  <= m0_d;
      m1_q  <= m1_d;
      irq_q <= irq_d;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (pg_go) begin
      mem_q[cell_addr] <= cell_new;
    end

  always_comb begin
    unique case (bus_addr)
      A_CTL:   bus_rdata = {2'b00, m1_q, m0_q, rie_q, win_open, busy, 1'b0};
      A_DAT:   bus_rdata = dat_q;
      A_ALO:   bus_rdata = alo_q;
      A_AHI:   bus_rdata = ahi_q;
      default: bus_rdata = 8'h00;
    endcase
  end

  assign ready_irq = irq_q;

  AST_READ_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> cpu_stall); // R2
  AST_PROG_STALLS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    pg_go |=> (cpu_stall && busy)); // R7
  AST_START_NEEDS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(win_open)); // R4
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ready_irq |=> !ready_irq); // R9
  AST_IRQ_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    ready_irq |-> (!busy && $past(busy))); // R9
endmodule

// File: tb/tb_nvm_ctrl.sv
`timescale 1ns/1ps
module tb_nvm_ctrl;
  localparam int E = 40;
  localparam int W = 24;
  localparam logic [7:0] CTL = 8'h3F, DAT = 8'h40, ALO = 8'h41, AHI = 8'h42;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       int_en_global = 1'b0;
  logic       cpu_stall, ready_irq;

  int checks = 0;
  int errors = 0;
  int exp_stall[$];
  int exp_irq[$];
  bit done = 1'b0;

  always #4 clk = ~clk;

  nvm_ctrl #(.ERASE_CYC(E), .WRITE_CYC(W)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .int_en_global(int_en_global), .cpu_stall(cpu_stall), .ready_irq(ready_irq));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitors: measure every stall and irq pulse and compare with the expected queues.
  int s_len = 0;
  int i_len = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (cpu_stall) s_len++;
      else if (s_len != 0) begin
        if (exp_stall.size() == 0) chk("R2/R7 unexpected stall", s_len, 0);
        else chk("R2/R7 stall length", s_len, exp_stall.pop_front());
        s_len = 0;
      end
      if (ready_irq) i_len++;
      else if (i_len != 0) begin
        if (exp_irq.size() == 0) chk("R9 unexpected irq", i_len, 0);
        else chk("R9 irq width", i_len, exp_irq.pop_front());
        i_len = 0;
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo);
    wr(AHI, hi); wr(ALO, lo);
  endtask

  task automatic cell_read(input logic [7:0] hi, input logic [7:0] lo, output logic [7:0] v);
    set_addr(hi, lo);
    wr(CTL, 8'h01);
    exp_stall.push_back(4);
    rd(DAT, v);
    idle(5);
  endtask

  // unlock + program with mode bits (m1 m0 rie in bits 5..3)
  task automatic prog(input logic [9:0] a, input logic [7:0] d, input logic [7:0] mode);
    wr(DAT, d);
    set_addr({6'b0, a[9:8]}, a[7:0]);
    wr(CTL, 8'h04 | mode);
    wr(CTL, 8'h02 | mode);
    exp_stall.push_back(2);
  endtask

  task automatic busy_len(output int n);
    logic [7:0] v;
    n = 0;
    rd(CTL, v);
    while (v[1] && n < 1000) begin
      n++;
      @(negedge clk);
      rd(CTL, v);
    end
  endtask

  initial begin
    #(8 * 150000);
    chk("watchdog", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    rd(CTL, v); chk("R1 ctrl", v, 0);
    rd(DAT, v); chk("R1 data", v, 0);
    rd(ALO, v); chk("R1 addr lo", v, 0);
    rd(AHI, v); chk("R1 addr hi", v, 0);
    chk("R1 stall", cpu_stall, 0);
    chk("R1 irq", ready_irq, 0);
    cell_read(8'h03, 8'hFF, v); chk("R1 erased top cell", v, 8'hFF);
    cell_read(8'h00, 8'h00, v); chk("R2 read cell 0", v, 8'hFF);

    // R5/R6 erase then write
    prog(10'h250, 8'h42, 8'h00);
    busy_len(n); chk("R6 erase+write busy", n, E + W);
    cell_read(8'h02, 8'h50, v); chk("R5 erase+write value", v, 8'h42);

    // R10 upper address bits ignored
    cell_read(8'hFE, 8'h50, v); chk("R10 upper bits ignored", v, 8'h42);

    // R5/R6 write only clears bits
    prog(10'h009, 8'h0F, 8'h00);
    busy_len(n);
    prog(10'h009, 8'h55, 8'h20);
    rd(CTL, v); chk("R6 mode bits held while busy", v[5:4], 2'b10);
    busy_len(n); chk("R6 write-only busy", n, W - 0);
    cell_read(8'h00, 8'h09, v); chk("R5 write-only AND", v, 8'h05);

    // R5/R6 erase only
    prog(10'h009, 8'h00, 8'h10);
    busy_len(n); chk("R6 erase-only busy", n, E);
    cell_read(8'h00, 8'h09, v); chk("R5 erase-only", v, 8'hFF);

    // R3 window readback
    wr(CTL, 8'h04);
    rd(CTL, v); chk("R3 mpe set", v[2], 1);
    idle(3);
    rd(CTL, v); chk("R3 mpe last cycle", v[2], 1);
    idle(1);
    rd(CTL, v); chk("R3 mpe cleared", v[2], 0);

    // R4 last accepting cycle
    wr(DAT, 8'h33); set_addr(8'h00, 8'h14);
    wr(CTL, 8'h04); idle(3); wr(CTL, 8'h02);
    exp_stall.push_back(2);
    rd(CTL, v); chk("R4 late-in-window accepted", v[1], 1);
    busy_len(n);
    cell_read(8'h00, 8'h14, v); chk("R4 accepted value", v, 8'h33);

    // R4 first rejecting cycle
    wr(DAT, 8'h00); set_addr(8'h00, 8'h14);
    wr(CTL, 8'h04); idle(4); wr(CTL, 8'h02);
    rd(CTL, v); chk("R4 rejected pe clear", v[1], 0);
    idle(4);
    cell_read(8'h00, 8'h14, v); chk("R4 rejected cell unchanged", v, 8'h33);

    // R8 request while busy
    prog(10'h00F, 8'h55, 8'h00);
    wr(DAT, 8'h66); set_addr(8'h00, 8'h10);
    wr(CTL, 8'h04); wr(CTL, 8'h02);
    busy_len(n); chk("R8 busy length kept", n, E + W - 5);
    cell_read(8'h00, 8'h0F, v); chk("R8 first cell", v, 8'h55);
    cell_read(8'h00, 8'h10, v); chk("R8 second ignored", v, 8'hFF);

    // R11 read wins over program
    wr(CTL, 8'h04); wr(CTL, 8'h03);
    exp_stall.push_back(4);
    rd(CTL, v); chk("R11 no programming", v[1], 0);
    rd(DAT, v); chk("R11 read done", v, 8'hFF);
    idle(5);

    // R9 interrupt enabled
    int_en_global = 1'b1;
    prog(10'h020, 8'hA5, 8'h08);
    exp_irq.push_back(1);
    busy_len(n);
    chk("R9 irq after busy clears", ready_irq, 1);
    idle(2);
    // R9 global disable blocks the pulse
    int_en_global = 1'b0;
    prog(10'h021, 8'hA5, 8'h08);
    busy_len(n);
    chk("R9 irq masked", ready_irq, 0);
    idle(2);
    // R9 local enable clear blocks the pulse
    int_en_global = 1'b1;
    prog(10'h022, 8'hA5, 8'h00);
    busy_len(n);
    chk("R9 irq not enabled", ready_irq, 0);
    idle(4);

    done = 1'b1;
    chk("R2/R7 missing stalls", exp_stall.size(), 0);
    chk("R9 missing irq", exp_irq.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule